// File: doc/BRIEF.md
# Memory Arbiter Performance Event Counters

This block sits next to a multi-client memory arbiter and counts selected arbitration and DRAM-access events. Every cycle the arbiter presents a sideband: whether a grant happened, the granted client's ID, the direction of the granted request, and the qualifier flags that came with it. These are the high-priority, timeout and bandwidth flags, plus page-miss, auto-precharge and the two bank-conflict indications. Two independent counter channels each pick one event type. Each can narrow it down to one client and to the state of one chosen priority flag. A shared cycle counter runs alongside the channels, so software can divide a channel count by the cycle count to get a utilisation ratio.

Software programs the unit through a small 32-bit register bus. It writes a configuration word per channel, sets a cycle limit that bounds the sampling window, and issues gather commands: reset, clear, freeze and run. It then reads the counts back. Reads are registered: data appears one cycle after the read strobe, qualified by a valid pulse. The event sideband is a plain per-cycle strobe, because an arbiter cannot be held off, so there is no back-pressure on that side. The register bus has no back-pressure either. It always accepts reads and writes in the cycle they are presented.

Top module: `arb_perf_counters`

## Requirements
- R1: Register offsets are 0x90 gather control, 0xA0 cycle limit, 0xA4 cycle count, 0xA8/0xAC channel 0/1 configuration, and 0xB8/0xBC channel 0/1 count. A read returns data with bus_rvalid in the cycle after bus_rd. Unmapped offsets read as zero. Writes to the count registers are ignored.
- R2: The gather command is bits 9:8 of a write to 0x90, with 0 = reset, 1 = clear, 2 = freeze and 3 = run. The unit comes out of hardware reset frozen. Counters change only while running, and a command takes effect from the following cycle. Reading 0x90 gives 0x300 while running and 0x200 while frozen.
- R3: Clear zeroes the cycle count and every channel count and leaves the run/freeze state unchanged. Reset zeroes them too, forces the frozen state, and forgets the previous-grant history. A clear overrides any increment in the same cycle.
- R4: While running, the cycle count rises by one per cycle until it reaches the cycle limit, then holds. The limit resets to all ones.
- R5: Channel counts rise by at most one per cycle and saturate at all ones.
- R6: The event select in configuration bits 23:16 is decoded as follows. Only cycles with arb_grant high can produce any event. 0 = any grant, 1 = read grant, 2 = write grant (arb_write high), 3 = direction change, 4 = successive win, 5 = bank-AA conflict, 6 = bank-BB conflict, 7 = page miss, 8 = auto-precharge. Codes above 8 count nothing.
- R7: A direction change is a grant whose direction differs from the previous grant's. The first grant after reset is never a change.
- R8: A successive win is a grant to the same client as the previous grant, so N back-to-back grants to one client add N-1. Cycles without a grant do not break the run.
- R9: With configuration bit 26 set, a channel counts only events whose arb_client equals bits 13:8. With bit 26 clear, it counts events from every client.
- R10: Bits 25:24 pick the priority flag: 0 = high-priority, 1 = timeout, 2 = bandwidth, 3 = a flag that always reads low. Bits 29:28 set the filter: 1 counts only when that flag is low, 2 counts only when it is high, and 0 or 3 ignore the flag.
- R11: The channels are independent. A configuration write takes effect in the following cycle, so an event arriving in the same cycle as the write is judged by the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| arb_grant | input | 1 | Arbiter granted a request this cycle |
| arb_client | input | 6 | ID of the granted client |
| arb_write | input | 1 | Granted request is a write |
| arb_hp | input | 1 | High-priority flag of the grant |
| arb_tm | input | 1 | Timeout flag of the grant |
| arb_bw | input | 1 | Bandwidth flag of the grant |
| arb_page_miss | input | 1 | Granted access missed the open page |
| arb_autopre | input | 1 | Granted access used auto-precharge |
| arb_bank_aa | input | 1 | Bank-AA conflict in this arbitration |
| arb_bank_bb | input | 1 | Bank-BB conflict in this arbitration |

## Verification
The assertions check, on every cycle, the rules that hold for any traffic. Read data arrives one cycle after the strobe. No counter moves while frozen. A clear zeroes the cycle count. The cycle count steps by at most one and stops at the limit. A saturated channel count never wraps. Whether the right events are counted can only be shown by the bench's scenarios, which drive known grant streams and compare read-back counts. These scenarios cover event decoding, turnaround and successive-win history, history loss on reset, client and priority filtering, and the old-configuration rule on a same-cycle write.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int CID_W  = 6;
  localparam int EV_NUM = 9;

  // event select codes (software visible)
  localparam int EV_GRANT     = 0;
  localparam int EV_READ      = 1;
  localparam int EV_WRITE     = 2;
  localparam int EV_TURN      = 3;
  localparam int EV_REPEAT    = 4;
  localparam int EV_BANK_AA   = 5;
  localparam int EV_BANK_BB   = 6;
  localparam int EV_PAGE_MISS = 7;
  localparam int EV_AUTOPRE   = 8;

  // register byte offsets
  localparam int OFS_GCTRL    = 'h90;
  localparam int OFS_LIMIT    = 'hA0;
  localparam int OFS_CYCLES   = 'hA4;
  localparam int OFS_CFG_BASE = 'hA8;
  localparam int OFS_CNT_BASE = 'hB8;

  typedef enum logic [1:0] {
    GCMD_RESET  = 2'd0,
    GCMD_CLEAR  = 2'd1,
    GCMD_FREEZE = 2'd2,
    GCMD_RUN    = 2'd3
  } gcmd_e;

  typedef struct packed {
    logic [1:0]       pfilt;
    logic             cfilt;
    logic [1:0]       psel;
    logic [7:0]       evsel;
    logic [CID_W-1:0] cid;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_from_word(input logic [31:0] w);
    chan_cfg_t c;
    c.cid   = w[13:8];
    c.evsel = w[23:16];
    c.psel  = w[25:24];
    c.cfilt = w[26];
    c.pfilt = w[29:28];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input chan_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[13:8]  = c.cid;
    w[23:16] = c.evsel;
    w[25:24] = c.psel;
    w[26]    = c.cfilt;
    w[29:28] = c.pfilt;
    return w;
  endfunction

endpackage

// File: rtl/perfmon_satcnt.sv
module perfmon_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (inc && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/perfmon_history.sv
module perfmon_history
  import perfmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hist_clr,
  input  logic             grant,
  input  logic [CID_W-1:0] client,
  input  logic             is_write,
  input  logic             page_miss,
  input  logic             autopre,
  input  logic             bank_aa,
  input  logic             bank_bb,
  output logic [EV_NUM-1:0] ev_vec
);

  logic             prev_vld;
  logic [CID_W-1:0] prev_client;
  logic             prev_write;

  always_ff @(posedge clk) begin
    if (!rst_n || hist_clr) begin
      prev_vld    <= 1'b0;
      prev_client <= '0;
      prev_write  <= 1'b0;
    end else if (grant) begin
      prev_vld    <= 1'b1;
      prev_client <= client;
      prev_write  <= is_write;
    end
  end

  always_comb begin
    ev_vec               = '0;
    ev_vec[EV_GRANT]     = grant;
    ev_vec[EV_READ]      = grant && !is_write;
    ev_vec[EV_WRITE]     = grant && is_write;
    ev_vec[EV_TURN]      = grant && prev_vld && (is_write != prev_write);
    ev_vec[EV_REPEAT]    = grant && prev_vld && (client == prev_client);
    ev_vec[EV_BANK_AA]   = grant && bank_aa;
    ev_vec[EV_BANK_BB]   = grant && bank_bb;
    ev_vec[EV_PAGE_MISS] = grant && page_miss;
    ev_vec[EV_AUTOPRE]   = grant && autopre;
  end

endmodule

// File: rtl/perfmon_channel.sv
module perfmon_channel
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic [EV_NUM-1:0] ev_vec,
  input  logic [CID_W-1:0]  client,
  input  logic              flag_hp,
  input  logic              flag_tm,
  input  logic              flag_bw,
  input  logic              count_en,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt
);

  logic ev_hit, cid_ok, pri_sig, pri_ok, bump;

  always_comb begin
    ev_hit = 1'b0;
    for (int k = 0; k < EV_NUM; k++) begin
      if (cfg.evsel == 8'(k)) ev_hit = ev_vec[k];
    end
  end

  assign cid_ok = !cfg.cfilt || (client == cfg.cid);

  always_comb begin
    case (cfg.psel)
      2'd0:    pri_sig = flag_hp;
      2'd1:    pri_sig = flag_tm;
      2'd2:    pri_sig = flag_bw;
      default: pri_sig = 1'b0;
    endcase
    case (cfg.pfilt)
      2'd1:    pri_ok = !pri_sig;
      2'd2:    pri_ok = pri_sig;
      default: pri_ok = 1'b1;
    endcase
  end

  assign bump = count_en && ev_hit && cid_ok && pri_ok;

  perfmon_satcnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (bump),
    .limit ({CNT_W{1'b1}}),
    .cnt   (cnt)
  );

endmodule

// File: rtl/arb_perf_counters.sv
module arb_perf_counters
  import perfmon_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              arb_grant,
  input  logic [5:0]        arb_client,
  input  logic              arb_write,
  input  logic              arb_hp,
  input  logic              arb_tm,
  input  logic              arb_bw,
  input  logic              arb_page_miss,
  input  logic              arb_autopre,
  input  logic              arb_bank_aa,
  input  logic              arb_bank_bb
);

  localparam logic [ADDR_W-1:0] A_GCTRL  = ADDR_W'(OFS_GCTRL);
  localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(OFS_LIMIT);
  localparam logic [ADDR_W-1:0] A_CYCLES = ADDR_W'(OFS_CYCLES);

  logic                            gather_en;
  logic [CNT_W-1:0]                clk_limit;
  logic [CNT_W-1:0]                clk_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0]    ch_cnt;
  chan_cfg_t                       cfg_q [NUM_CH];
  logic [EV_NUM-1:0]               ev_vec;
  logic                            gwr;
  gcmd_e                           gcmd;
  logic                            cnt_clr;
  logic                            hist_clr;
  logic [31:0]                     rd_mux;

  // gather control
  assign gwr      = bus_wr && (bus_addr == A_GCTRL);
  assign gcmd     = gcmd_e'(bus_wdata[9:8]);
  assign cnt_clr  = gwr && ((gcmd == GCMD_RESET) || (gcmd == GCMD_CLEAR));
  assign hist_clr = gwr && (gcmd == GCMD_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gather_en <= 1'b0;
    end else if (gwr) begin
      case (gcmd)
        GCMD_RUN:                gather_en <= 1'b1;
        GCMD_RESET, GCMD_FREEZE: gather_en <= 1'b0;
        default:                 gather_en <= gather_en;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_limit <= '1;
    end else if (bus_wr && (bus_addr == A_LIMIT)) begin
      clk_limit <= bus_wdata[CNT_W-1:0];
    end
  end

  perfmon_satcnt #(.W(CNT_W)) u_cycles (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (gather_en),
    .limit (clk_limit),
    .cnt   (clk_cnt)
  );

  perfmon_history u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .hist_clr  (hist_clr),
    .grant     (arb_grant),
    .client    (arb_client),
    .is_write  (arb_write),
    .page_miss (arb_page_miss),
    .autopre   (arb_autopre),
    .bank_aa   (arb_bank_aa),
    .bank_bb   (arb_bank_bb),
    .ev_vec    (ev_vec)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG_BASE + 4 * i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (bus_wr && (bus_addr == A_CFG)) begin
        cfg_q[i] <= cfg_from_word(bus_wdata);
      end
    end

    perfmon_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q[i]),
      .ev_vec   (ev_vec),
      .client   (arb_client),
      .flag_hp  (arb_hp),
      .flag_tm  (arb_tm),
      .flag_bw  (arb_bw),
      .count_en (gather_en),
      .cnt_clr  (cnt_clr),
      .cnt      (ch_cnt[i])
    );
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_GCTRL)  rd_mux = {22'd0, 1'b1, gather_en, 8'd0};
    if (bus_addr == A_LIMIT)  rd_mux = 32'(clk_limit);
    if (bus_addr == A_CYCLES) rd_mux = 32'(clk_cnt);
    for (int k = 0; k < NUM_CH; k++) begin
      if (bus_addr == ADDR_W'(OFS_CFG_BASE + 4 * k)) rd_mux = cfg_to_word(cfg_q[k]);
      if (bus_addr == ADDR_W'(OFS_CNT_BASE + 4 * k)) rd_mux = 32'(ch_cnt[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/arb_perf_counters_chk.sv
module arb_perf_counters_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_rd,
  input logic                         bus_rvalid,
  input logic                         gather_en,
  input logic                         cnt_clr,
  input logic [CNT_W-1:0]             clk_cnt,
  input logic [CNT_W-1:0]             clk_limit,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);  // R1

  AST_FROZEN_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!gather_en && !cnt_clr) |=> $stable(clk_cnt));  // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (clk_cnt == '0));  // R3

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> ((clk_cnt == $past(clk_cnt)) || (clk_cnt == $past(clk_cnt) + 1'b1)));  // R4

  AST_CYCLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && (clk_cnt >= clk_limit)) |=> $stable(clk_cnt));  // R4

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clr && (ch_cnt[i] == '1)) |=> (ch_cnt[i] == '1));  // R5

    AST_CH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> ((ch_cnt[i] == $past(ch_cnt[i])) || (ch_cnt[i] == $past(ch_cnt[i]) + 1'b1)));  // R5

    AST_CH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!gather_en && !cnt_clr) |=> $stable(ch_cnt[i]));  // R2
  end

endmodule

bind arb_perf_counters arb_perf_counters_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid),
  .gather_en  (gather_en),
  .cnt_clr    (cnt_clr),
  .clk_cnt    (clk_cnt),
  .clk_limit  (clk_limit),
  .ch_cnt     (ch_cnt)
);

// File: tb/tb_arb_perf_counters.sv
`timescale 1ns/1ps
module tb_arb_perf_counters;

  localparam int CNT_W  = 8;
  localparam int ADDR_W = 12;

  localparam logic [11:0] A_GC  = 12'h090;
  localparam logic [11:0] A_LIM = 12'h0A0;
  localparam logic [11:0] A_CYC = 12'h0A4;
  localparam logic [11:0] A_C0  = 12'h0A8;
  localparam logic [11:0] A_C1  = 12'h0AC;
  localparam logic [11:0] A_N0  = 12'h0B8;
  localparam logic [11:0] A_N1  = 12'h0BC;

  typedef struct packed {
    logic       g;
    logic [5:0] c;
    logic       w, hp, tm, bw, pm, ap, aa, bb;
  } ev_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  ev_t               ev = '0;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  arb_perf_counters #(.NUM_CH(2), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .arb_grant(ev.g), .arb_client(ev.c), .arb_write(ev.w),
    .arb_hp(ev.hp), .arb_tm(ev.tm), .arb_bw(ev.bw),
    .arb_page_miss(ev.pm), .arb_autopre(ev.ap),
    .arb_bank_aa(ev.aa), .arb_bank_bb(ev.bb)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R1 unexpected read data: got %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        nvec++;
        if (bus_rdata !== e) begin
          nfail++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  function automatic logic [31:0] ctl(input int cid, input int evs, input int psel,
                                      input int cf, input int pf);
    return (32'(pf) << 28) | (32'(cf) << 26) | (32'(psel) << 24) |
           (32'(evs) << 16) | (32'(cid) << 8);
  endfunction

  function automatic ev_t gnt(input int c, input bit w);
    ev_t e;
    e = '0; e.g = 1'b1; e.c = 6'(c); e.w = w;
    return e;
  endfunction

  task automatic cyc(input logic wr, input logic rd, input logic [11:0] a,
                     input logic [31:0] d, input ev_t e);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ev = e;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic cmd(input int code);
    wr(A_GC, 32'(code) << 8);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cyc(1'b0, 1'b1, a, '0, '0);
  endtask

  task automatic fire(input ev_t e);
    cyc(1'b0, 1'b0, '0, '0, e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    ev_t e;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // reset state
    rd(A_GC,   32'h200, "R2 reset state frozen");
    rd(A_LIM,  32'hFF,  "R4 limit reset all ones");
    rd(A_CYC,  32'h0,   "R1 cycle count reset");
    rd(A_C0,   32'h0,   "R1 cfg0 reset");
    rd(A_N1,   32'h0,   "R1 count1 reset");
    rd(12'h094, 32'h0,  "R1 unmapped reads zero");

    // basic counting, independent channels
    wr(A_C0, ctl(0, 0, 0, 0, 0));
    wr(A_C1, ctl(0, 1, 0, 0, 0));
    fire(gnt(1, 0));                 // frozen: ignored
    cmd(3);
    fire(gnt(1, 0)); fire(gnt(2, 1)); fire(gnt(3, 0));
    cmd(2);
    fire(gnt(1, 0));                 // frozen: ignored
    rd(A_N0, 32'd3, "R6 R2 grants counted only while running");
    rd(A_N1, 32'd2, "R11 R6 read-only channel");
    rd(A_CYC, 32'd4, "R4 cycle count over run window");
    rd(A_GC, 32'h200, "R2 frozen readback");
    rd(A_C1, 32'h0001_0000, "R1 cfg1 readback");
    wr(A_CYC, 32'h55);
    rd(A_CYC, 32'd4, "R1 cycle count write ignored");
    wr(A_N0, 32'h11);
    rd(A_N0, 32'd3, "R1 channel count write ignored");

    // clear
    cmd(1);
    rd(A_GC, 32'h200, "R3 clear keeps frozen");
    rd(A_CYC, 32'd0, "R3 clear zeroes cycles");
    rd(A_N1, 32'd0, "R3 clear zeroes channel");
    cmd(3); cmd(1);
    rd(A_GC, 32'h300, "R3 R2 clear keeps running");
    cmd(2);
    rd(A_CYC, 32'd2, "R3 clear beats increment");

    // reset command, history loss, successive wins, client filter
    cmd(3); cmd(0);
    rd(A_GC, 32'h200, "R3 reset freezes");
    rd(A_CYC, 32'd0, "R3 reset zeroes cycles");
    wr(A_C0, ctl(0, 4, 0, 0, 0));
    wr(A_C1, ctl(5, 0, 0, 1, 0));
    fire(gnt(5, 1));
    cmd(0); cmd(3);
    fire(gnt(5, 0)); fire(gnt(5, 0)); idle(1); fire(gnt(5, 0)); fire(gnt(7, 0));
    cmd(2);
    rd(A_N0, 32'd2, "R8 R3 successive wins after history reset");
    rd(A_N1, 32'd3, "R9 client filter");
    rd(A_CYC, 32'd6, "R4 cycle count");

    // direction change and writes
    cmd(0);
    wr(A_C0, ctl(0, 3, 0, 0, 0));
    wr(A_C1, ctl(0, 2, 0, 0, 0));
    cmd(3);
    fire(gnt(1, 0)); fire(gnt(2, 0)); fire(gnt(1, 1));
    e = '0; e.w = 1'b1; e.c = 6'd1; fire(e);         // no grant
    fire(gnt(2, 1)); fire(gnt(3, 0));
    cmd(2);
    rd(A_N0, 32'd2, "R7 direction changes");
    rd(A_N1, 32'd2, "R6 write grants");

    // priority filter: timeout asserted / bandwidth deasserted
    cmd(0);
    wr(A_C0, ctl(0, 0, 1, 0, 2));
    wr(A_C1, ctl(0, 0, 2, 0, 1));
    cmd(3);
    e = gnt(1, 0); e.tm = 1'b1; fire(e);
    e = gnt(1, 0); e.tm = 1'b1; e.bw = 1'b1; fire(e);
    fire(gnt(2, 0));
    e = gnt(2, 0); e.hp = 1'b1; fire(e);
    cmd(2);
    rd(A_N0, 32'd2, "R10 timeout flag asserted filter");
    rd(A_N1, 32'd3, "R10 bandwidth flag deasserted filter");

    // priority filter: high priority, mode 3 ignores flag
    cmd(0);
    wr(A_C0, ctl(0, 0, 0, 0, 2));
    wr(A_C1, ctl(0, 0, 0, 0, 3));
    cmd(3);
    e = gnt(1, 0); e.hp = 1'b1; fire(e);
    fire(gnt(1, 0));
    e = gnt(1, 0); e.hp = 1'b1; e.tm = 1'b1; fire(e);
    cmd(2);
    rd(A_N0, 32'd2, "R10 high-priority asserted filter");
    rd(A_N1, 32'd3, "R10 filter mode 3 ignores flag");

    // page miss / auto-precharge
    cmd(0);
    wr(A_C0, ctl(0, 7, 0, 0, 0));
    wr(A_C1, ctl(0, 8, 0, 0, 0));
    cmd(3);
    e = gnt(1, 0); e.pm = 1'b1; fire(e);
    e = gnt(1, 0); e.ap = 1'b1; fire(e);
    e = gnt(1, 0); e.pm = 1'b1; e.ap = 1'b1; fire(e);
    e = '0; e.pm = 1'b1; e.ap = 1'b1; fire(e);        // no grant
    cmd(2);
    rd(A_N0, 32'd2, "R6 page miss");
    rd(A_N1, 32'd2, "R6 auto-precharge");

    // bank conflicts
    cmd(0);
    wr(A_C0, ctl(0, 5, 0, 0, 0));
    wr(A_C1, ctl(0, 6, 0, 0, 0));
    cmd(3);
    e = gnt(1, 0); e.aa = 1'b1; fire(e);
    e = gnt(1, 0); e.bb = 1'b1; fire(e);
    e = gnt(1, 0); e.aa = 1'b1; fire(e);
    cmd(2);
    rd(A_N0, 32'd2, "R6 bank AA");
    rd(A_N1, 32'd1, "R6 bank BB");

    // undefined event code, read filtered by client
    cmd(0);
    wr(A_C0, ctl(0, 9, 0, 0, 0));
    wr(A_C1, ctl(2, 1, 0, 1, 0));
    cmd(3);
    fire(gnt(2, 0)); fire(gnt(3, 0)); fire(gnt(2, 1));
    cmd(2);
    rd(A_N0, 32'd0, "R6 undefined code counts nothing");
    rd(A_N1, 32'd1, "R9 R6 client-filtered reads");

    // cycle limit
    cmd(0);
    wr(A_LIM, 32'd5);
    cmd(3);
    idle(10);
    cmd(2);
    rd(A_CYC, 32'd5, "R4 cycle count stops at limit");
    rd(A_LIM, 32'd5, "R4 limit readback");

    // saturation
    cmd(0);
    wr(A_LIM, 32'hFF);
    wr(A_C0, ctl(0, 0, 0, 0, 0));
    cmd(3);
    for (int i = 0; i < 300; i++) fire(gnt(4, 0));
    cmd(2);
    rd(A_N0, 32'hFF, "R5 channel saturates");
    rd(A_CYC, 32'hFF, "R4 cycle count saturates at limit");

    // configuration write timing
    cmd(0);
    wr(A_C0, ctl(0, 0, 0, 0, 0));
    cmd(3);
    cyc(1'b1, 1'b0, A_C0, ctl(9, 0, 0, 1, 0), gnt(1, 0));   // old cfg applies
    fire(gnt(1, 0));
    fire(gnt(9, 0));
    cmd(2);
    rd(A_N0, 32'd2, "R11 cfg write takes effect next cycle");

    idle(4);
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R1 missing read data: got %0d pending expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule